// File: doc/BRIEF.md
# Fixed-Point Quadratic Spiking Neuron

This block updates the state of a single two-variable spiking neuron. It holds a membrane potential `v` and a recovery variable `u`. When an update request is accepted, it advances both variables by one forward-Euler step of 1 ms. The membrane derivative is `0.04·v² + 5·v + 140 − u + I`, where `v` is in millivolts. The recovery derivative is `a·(b·v − u)`.

When the new membrane value is at or above +30 mV, the block reports a spike. On a spike, the membrane is reloaded with `c` and the recovery variable is raised by `d`. All four shape parameters (`a`, `b`, `c`, `d`) and the input current are sampled together with each request. A host can therefore retune the firing behaviour between steps without reset.

A valid/ready handshake guards the request. Each accepted request takes two cycles: one to capture the operands and one to commit the new state. A source that holds `inValid` high is throttled automatically.

Top module: `izh_neuron`

## Requirements
- R1: During synchronous reset (`rst` high), `vOut` becomes −16640 (−65.0 mV in signed Q8.8). `uOut` becomes `floor(parB · (−16640) / 4096)`, saturated to 16 bits, using the `parB` value present during reset. `spike` is 0 and `inReady` is 1.
- R2: `inReady` is 1 while the block is idle. A request is accepted on a rising edge where `inValid` and `inReady` are both 1. `inReady` is 0 for exactly the one following cycle. The updated state is visible after the next rising edge.
- R3: `v`, `u`, `I`, `c` and `d` are signed Q8.8 (16 bits). The new membrane value is `sat(V + Q + L + 35840 − U + I)`, where `Q = sat(floor(V·V·2621 / 2^24))` and `L = sat(5·V)`.
- R4: `a` and `b` are unsigned Q4.12 (16 bits). The new recovery value is `sat(U + sat(floor(a·(sat(floor(b·V/4096)) − U)/4096)))`. Both new values are computed from the previous `V` and `U`.
- R5: A spike occurs when the freshly computed membrane value is ≥ 7680 (+30.0 mV). A value of 7679 gives no spike.
- R6: On a spike, `vOut` takes `c` and `uOut` takes `sat(newU + d)`. Otherwise `vOut` and `uOut` take the computed values.
- R7: `spike` is high for exactly one clock. That clock is the cycle in which the post-update state first appears on `vOut` and `uOut`.
- R8: Every saturation clamps to the range [−32768, 32767] and never wraps.
- R9: Without an accepted request, `vOut`, `uOut` and `spike` (0) do not change, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Update request |
| inReady | output | 1 | Block can accept a request |
| current | input | 16 | Input current I, signed Q8.8 |
| parA | input | 16 | Recovery rate a, unsigned Q4.12 |
| parB | input | 16 | Recovery sensitivity b, unsigned Q4.12 |
| parC | input | 16 | Post-spike membrane value c, signed Q8.8 |
| parD | input | 16 | Post-spike recovery increment d, signed Q8.8 |
| spike | output | 1 | One-cycle spike pulse |
| vOut | output | 16 | Membrane potential, signed Q8.8 |
| uOut | output | 16 | Recovery variable, signed Q8.8 |

## Verification
The hardest situation to reach is a step whose new membrane value lands exactly on the threshold, or one unit below it. The state is set only by reset or by a spike reload, so the bench first forces a spike with a large current. That spike places `v` at a chosen `c`, and a zero rate `a` keeps `u` known. The bench then solves for the single current value that makes the next step produce exactly 7680, and also applies that current minus one. Sweeps over rates, membrane starting points and currents cover the ordinary dynamics. Extreme `c`, `d` and current values drive each saturation point to its limits.

// File: rtl/izh_pkg.sv
package izh_pkg;
  localparam int DATA_W   = 16;
  localparam int FRAC_W   = 8;
  localparam int PAR_W    = 16;
  localparam int PAR_FRAC = 12;
  localparam int ACC_W    = 64;

  typedef logic signed [DATA_W-1:0] state_t;
  typedef logic        [PAR_W-1:0]  par_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t STATE_MAX = acc_t'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam acc_t STATE_MIN = -STATE_MAX - acc_t'(1);
  localparam acc_t K_QUAD    = acc_t'((4 << (2*FRAC_W)) / 100);
  localparam acc_t BIAS_V    = acc_t'(140 <<< FRAC_W);
  localparam acc_t THRESH_V  = acc_t'(30 <<< FRAC_W);
  localparam acc_t REST_V    = -acc_t'(65 <<< FRAC_W);

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrl_strb_t;

  typedef enum logic {ST_IDLE, ST_EXEC} ctrl_state_t;

  function automatic state_t satState(input acc_t x);
    if (x > STATE_MAX) return state_t'(STATE_MAX);
    if (x < STATE_MIN) return state_t'(STATE_MIN);
    return state_t'(x);
  endfunction
endpackage

// File: rtl/izh_ctrl.sv
module izh_ctrl
  import izh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  output ctrl_strb_t strb
);
  ctrl_state_t curState;

  assign inReady      = (curState == ST_IDLE);
  assign strb.capture = inValid && inReady;
  assign strb.commit  = (curState == ST_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_IDLE;
    end else begin
      unique case (curState)
        ST_IDLE: if (strb.capture) curState <= ST_EXEC;
        ST_EXEC: curState <= ST_IDLE;
        default: curState <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/izh_datapath.sv
module izh_datapath
  import izh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_strb_t strb,
  input  state_t     current,
  input  par_t       parA,
  input  par_t       parB,
  input  state_t     parC,
  input  state_t     parD,
  output logic       spike,
  output state_t     vOut,
  output state_t     uOut
);
  state_t vReg, uReg, iReg, cReg, dReg;
  par_t   aReg, bReg;
  logic   spikeReg;

  acc_t   vW, uW, dvSum;
  state_t quadS, linS, vNew, bvS, duS, uNew, uBumped, uRst;
  logic   fire;

  // One Euler step of 1 ms, every partial result clamped to the state range
  always_comb begin
    vW      = acc_t'(vReg);
    uW      = acc_t'(uReg);
    quadS   = satState((vW * vW * K_QUAD) >>> (3*FRAC_W));
    linS    = satState(vW * acc_t'(5));
    dvSum   = acc_t'(quadS) + acc_t'(linS) + BIAS_V - uW + acc_t'(iReg);
    vNew    = satState(vW + dvSum);
    bvS     = satState((acc_t'(bReg) * vW) >>> PAR_FRAC);
    duS     = satState((acc_t'(aReg) * (acc_t'(bvS) - uW)) >>> PAR_FRAC);
    uNew    = satState(uW + acc_t'(duS));
    fire    = (acc_t'(vNew) >= THRESH_V);
    uBumped = satState(acc_t'(uNew) + acc_t'(dReg));
    uRst    = satState((acc_t'(parB) * REST_V) >>> PAR_FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vReg     <= state_t'(REST_V);
      uReg     <= uRst;
      spikeReg <= 1'b0;
      iReg     <= '0;
      aReg     <= '0;
      bReg     <= '0;
      cReg     <= '0;
      dReg     <= '0;
    end else begin
      if (strb.capture) begin
        iReg <= current;
        aReg <= parA;
        bReg <= parB;
        cReg <= parC;
        dReg <= parD;
      end
      if (strb.commit) begin
        vReg     <= fire ? cReg : vNew;
        uReg     <= fire ? uBumped : uNew;
        spikeReg <= fire;
      end else begin
        spikeReg <= 1'b0;
      end
    end
  end

  assign spike = spikeReg;
  assign vOut  = vReg;
  assign uOut  = uReg;
endmodule

// File: rtl/izh_neuron.sv
module izh_neuron
  import izh_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] current,
  input  logic        [PAR_W-1:0]  parA,
  input  logic        [PAR_W-1:0]  parB,
  input  logic signed [DATA_W-1:0] parC,
  input  logic signed [DATA_W-1:0] parD,
  output logic                     spike,
  output logic signed [DATA_W-1:0] vOut,
  output logic signed [DATA_W-1:0] uOut
);
  ctrl_strb_t strb;

  izh_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb)
  );

  izh_datapath i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .current (current),
    .parA    (parA),
    .parB    (parB),
    .parC    (parC),
    .parD    (parD),
    .spike   (spike),
    .vOut    (vOut),
    .uOut    (uOut)
  );
endmodule

// File: rtl/izh_neuron_chk.sv
module izh_neuron_chk
  import izh_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     inReady,
  input logic signed [DATA_W-1:0] parC,
  input logic                     spike,
  input logic signed [DATA_W-1:0] vOut,
  input logic signed [DATA_W-1:0] uOut
);
  // R7: the pulse never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    spike |=> !spike);

  // R7: a pulse appears only right after the commit cycle
  a_r7_pulse_after_commit: assert property (@(posedge clk) disable iff (rst)
    spike |-> !$past(inReady));

  // R2: busy lasts exactly one cycle
  a_r2_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> inReady);

  // R6: after a spike the membrane holds the c sampled at acceptance
  a_r6_reload_c: assert property (@(posedge clk) disable iff (rst)
    spike |-> (vOut == $past(parC, 2)));

  // R5: a committed step without spike leaves v below threshold
  a_r5_below_thresh: assert property (@(posedge clk) disable iff (rst)
    (!spike && !$past(inReady) && !$past(rst)) |-> (acc_t'(vOut) < THRESH_V));

  // R9: no commit in the previous cycle means the state is unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(inReady) && !$past(rst)) |-> ($stable(vOut) && $stable(uOut)));
endmodule

bind izh_neuron izh_neuron_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .inReady (inReady),
  .parC    (parC),
  .spike   (spike),
  .vOut    (vOut),
  .uOut    (uOut)
);

// File: tb/test_izh_neuron.sv
module test_izh_neuron;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [15:0] current = '0;
  logic [15:0] parA = '0;
  logic [15:0] parB = '0;
  logic signed [15:0] parC = '0;
  logic signed [15:0] parD = '0;
  logic spike;
  logic signed [15:0] vOut, uOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  longint mV, mU;

  always #10 clk = ~clk;

  izh_neuron i_izh_neuron (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .current(current), .parA(parA), .parB(parB), .parC(parC), .parD(parD),
    .spike(spike), .vOut(vOut), .uOut(uOut)
  );

  function automatic longint sat(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 R4 R5 R6 reference step
  task automatic model(input longint i, a, b, c, d, output longint nv, nu, output bit sp);
    longint q, l, dv, v0, bv, du, u0;
    q  = sat((mV * mV * 2621) >>> 24);
    l  = sat(5 * mV);
    dv = q + l + 35840 - mU + i;
    v0 = sat(mV + dv);
    bv = sat((b * mV) >>> 12);
    du = sat((a * (bv - mU)) >>> 12);
    u0 = sat(mU + du);
    sp = (v0 >= 7680);
    nv = sp ? c : v0;
    nu = sp ? sat(u0 + d) : u0;
  endtask

  task automatic doReset(input longint b);
    rst = 1'b1; inValid = 1'b0; parB = 16'(b);
    @(negedge clk); @(negedge clk);
    mV = -16640;
    mU = sat((b * -16640) >>> 12);
    chk(vOut == -16640, "R1 reset v", longint'(vOut), -16640);
    chk(longint'(uOut) == mU, "R1 reset u", longint'(uOut), mU);
    chk(spike == 1'b0, "R1 reset spike", longint'(spike), 0);
    chk(inReady == 1'b1, "R1 reset ready", longint'(inReady), 1);
    rst = 1'b0;
  endtask

  task automatic doStep(input longint i, a, b, c, d);
    longint nv, nu;
    bit sp;
    @(negedge clk);
    chk(inReady == 1'b1, "R2 idle ready", longint'(inReady), 1);
    inValid = 1'b1; current = 16'(i); parA = 16'(a); parB = 16'(b);
    parC = 16'(c); parD = 16'(d);
    @(negedge clk);
    inValid = 1'b0;
    current = ~current; parC = ~parC; parD = ~parD;
    chk(inReady == 1'b0, "R2 busy", longint'(inReady), 0);
    @(negedge clk);
    model(i, a, b, c, d, nv, nu, sp);
    chk(spike == sp, "R5 spike", longint'(spike), longint'(sp));
    chk(longint'(vOut) == nv, "R3/R6 v", longint'(vOut), nv);
    chk(longint'(uOut) == nu, "R4/R6 u", longint'(uOut), nu);
    mV = nv; mU = nu;
    if (sp) begin
      @(negedge clk);
      chk(spike == 1'b0, "R7 pulse width", longint'(spike), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint sv, su, need;
    doReset(819);
    doReset(1024);

    // Sweep rates, starting membrane and currents (R3 R4 R5 R6)
    foreach (parA[k]) begin end
    for (int ai = 0; ai < 3; ai++) begin
      for (int bi = 0; bi < 2; bi++) begin
        longint av, bv;
        av = (ai == 0) ? 0 : (ai == 1) ? 82 : 410;
        bv = (bi == 0) ? 819 : 1024;
        doReset(bv);
        for (int cv = -80; cv <= 40; cv += 8) begin
          doStep(32767, 0, bv, cv * 256, 0);
          for (int ii = 0; ii < 5; ii++) begin
            longint iv;
            iv = (ii == 0) ? -20 : (ii == 1) ? 0 : (ii == 2) ? 5 : (ii == 3) ? 20 : 60;
            doStep(iv * 256, av, bv, -65 * 256, 8 * 256);
          end
        end
      end
    end

    // R5: land exactly on and just below the threshold
    doReset(819);
    for (int vs = -10; vs <= 10; vs++) begin
      for (int off = 0; off < 2; off++) begin
        longint q, l;
        doStep(32767, 0, 819, vs * 256, 0);
        sv = mV; su = mU;
        q = sat((sv * sv * 2621) >>> 24);
        l = sat(5 * sv);
        need = 7680 - sv - (q + l + 35840 - su) - off;
        if (need >= -32768 && need <= 32767) begin
          doStep(need, 0, 819, 100, 0);
          chk(vOut == ((off == 0) ? 16'sd100 : 16'sd7679), "R5 exact threshold",
              longint'(vOut), (off == 0) ? 100 : 7679);
        end
      end
    end

    // R8: saturation at both ends
    doReset(819);
    doStep(32767, 0, 819, 32767, 32767);
    doStep(32767, 0, 819, 32767, 32767);
    chk(uOut == 16'sd32767, "R8 u clamps high", longint'(uOut), 32767);
    doStep(32767, 0, 819, -32768, 0);
    doStep(-32768, 0, 0, 0, 0);
    chk(vOut == -16'sd32768, "R8 v clamps low", longint'(vOut), -32768);
    doStep(0, 65535, 65535, 0, -32768);

    // R9: state holds while inputs move without a request
    doReset(1024);
    doStep(0, 82, 1024, -16640, 0);
    sv = mV; su = mU;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      current = 16'(n * 4000); parC = 16'(n * 777); parD = 16'(n * 99);
      chk(longint'(vOut) == sv, "R9 v hold", longint'(vOut), sv);
      chk(longint'(uOut) == su, "R9 u hold", longint'(uOut), su);
      chk(spike == 1'b0, "R9 no spike", longint'(spike), 0);
    end

    // R2: inValid held high gives one update every two cycles
    begin
      longint nv, nu;
      bit sp;
      @(negedge clk);
      inValid = 1'b1; current = 16'sd256; parA = 16'd82; parB = 16'd1024;
      parC = -16'sd16640; parD = 16'sd0;
      @(negedge clk);
      chk(inReady == 1'b0, "R2 stall 1", longint'(inReady), 0);
      @(negedge clk);
      model(256, 82, 1024, -16640, 0, nv, nu, sp);
      mV = nv; mU = nu;
      chk(longint'(vOut) == nv, "R2 first update", longint'(vOut), nv);
      chk(inReady == 1'b1, "R2 ready again", longint'(inReady), 1);
      @(negedge clk);
      chk(inReady == 1'b0, "R2 stall 2", longint'(inReady), 0);
      inValid = 1'b0;
      @(negedge clk);
      model(256, 82, 1024, -16640, 0, nv, nu, sp);
      mV = nv; mU = nu;
      chk(longint'(vOut) == nv, "R2 second update", longint'(vOut), nv);
      chk(longint'(uOut) == nu, "R2 second update u", longint'(uOut), nu);
      @(negedge clk);
      chk(longint'(vOut) == nv, "R2 no third update", longint'(vOut), nv);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule